// File: doc/BRIEF.md
# Smart Card Interrupt and DMA Request Unit

This block sits beside the transmit and receive engines of an ISO 7816 style smart card serial port. It turns their events into CPU interrupt lines and a transmit DMA request. Each engine reports an event with a one-cycle set pulse on one bit. The block holds seven status flags. Software reads the flags over a small register port and clears them by writing ones. A control register holds the enable bits that decide which flags reach the interrupt controller.

There are four interrupt lines: transmit-empty, receive-full, error and transmit-done. Each one is driven on its own. The error line collects four sources under two different enables. The receive-full line has an extra bit that keeps it from the CPU, so a DMA engine can service reception instead. A transmit DMA request follows the transmit-empty flag. It is withheld while the transmit engine runs an automatic T=0 retransmission after the card signals an error, so the byte count programmed into the DMA engine stays correct.

Top module: `sc_irq_dma_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output goes to 0. The status register resets to 0x03 (tx_empty and tx_done set, every other flag clear). The control register resets to 0x00.
- R2: The status register is at address 0. Its bits are: 0 tx_empty, 1 tx_done, 2 rx_full, 3 card_err, 4 overrun, 5 parity_err, 6 wait_timeout. A pulse on `flag_set[i]` sets flag i at that edge. A write to address 0 clears every flag whose `wr_data` bit is 1. When a set and a clear reach the same flag in the same cycle, the set wins.
- R3: A pulse on `tdr_wr` clears tx_empty, unless `flag_set[0]` is high in the same cycle.
- R4: The control register is at address 1 and is read/write. Its bits are: 0 txe_en, 1 rx_en, 2 txd_en, 3 wait_en, 4 rx_cpu_off. Unused data bits are ignored.
- R5: One cycle after the state that causes it, `irq_tx_empty` equals tx_empty AND txe_en.
- R6: One cycle after the state that causes it, `irq_tx_done` equals tx_done AND txd_en.
- R7: One cycle after the state that causes it, `irq_rx_full` equals rx_full AND rx_en AND NOT rx_cpu_off.
- R8: One cycle after the state that causes it, `irq_err` equals ((card_err OR overrun OR parity_err) AND rx_en) OR (wait_timeout AND wait_en).
- R9: One cycle after the state that causes it, `dma_tx_req` equals tx_empty AND NOT `retx_active`. It is held as a level until tx_empty clears.
- R10: `rd_data` is registered. It returns the register selected by `rd_addr` one cycle later, with the value that register held before that edge. Addresses 2 and above read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flag_set | input | 7 | One-cycle set pulses from the engines, one bit per flag |
| tdr_wr | input | 1 | Pulse: transmit data register written, clears tx_empty |
| retx_active | input | 1 | High while a T=0 automatic retransmission is running |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data (ones clear flags at address 0) |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Registered read data |
| irq_tx_empty | output | 1 | Transmit-empty interrupt |
| irq_rx_full | output | 1 | Receive-full interrupt |
| irq_err | output | 1 | Combined error interrupt |
| irq_tx_done | output | 1 | Transmit-done interrupt |
| dma_tx_req | output | 1 | Transmit DMA request level |

## Verification
An engine set pulse and a software write-one-to-clear can land on the same flag in the same cycle. For tx_empty, a DMA write of the data register can land there as well. A directed phase drives all three together on every flag. A long random phase makes sets, clears, data-register writes and retransmission windows overlap freely. A reference model in the bench is compared with every output on every clock. It lets the set win, and it must show the flag still high both in the status read-back and in the interrupt and DMA lines of the next cycle.

// File: rtl/sc_irq_pkg.sv
// Package: shared bit positions and widths for the smart card interrupt unit.
// Assumes the status and control layouts below are fixed by the software view.
package sc_irq_pkg;

    localparam int NUM_FLAGS = 7;
    localparam int NUM_CTRL  = 5;

    // status flag bit positions
    localparam int F_TX_EMPTY = 0;
    localparam int F_TX_DONE  = 1;
    localparam int F_RX_FULL  = 2;
    localparam int F_CARD_ERR = 3;
    localparam int F_OVERRUN  = 4;
    localparam int F_PARITY   = 5;
    localparam int F_WAIT_TO  = 6;

    // control bit positions
    localparam int C_TXE_EN  = 0;
    localparam int C_RX_EN   = 1;
    localparam int C_TXD_EN  = 2;
    localparam int C_WAIT_EN = 3;
    localparam int C_CPU_OFF = 4;

    // register addresses
    localparam int ADDR_STATUS = 0;
    localparam int ADDR_CTRL   = 1;

    // reset value of the status flags: transmitter idle and empty
    localparam logic [NUM_FLAGS-1:0] FLAG_RST = 7'b000_0011;

    typedef struct packed {
        logic tx_empty;
        logic rx_full;
        logic err;
        logic tx_done;
        logic dma;
    } req_t;

endpackage

// File: rtl/sc_flag_bank.sv
// Module: sc_flag_bank
// Holds N sticky status flags. Each bit is set by a pulse and cleared by a
// clear request; set has priority over clear. Reset value per bit from RST.
// Assumes set and clr are synchronous single-cycle qualifiers.
module sc_flag_bank #(
    parameter int N = 7,
    parameter logic [N-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        // one flag: reset value, set wins over clear
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[i] <= RST[i];
            end else if (set[i]) begin
                q[i] <= 1'b1;
            end else if (clr[i]) begin
                q[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sc_ctrl_reg.sv
// Module: sc_ctrl_reg
// Plain read/write register of W enable bits, loaded when we is high.
// Assumes the caller has already decoded the address.
module sc_ctrl_reg #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // load enables on write, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= d;
        end
    end

endmodule

// File: rtl/sc_req_gen.sv
// Module: sc_req_gen
// Combines the flags with the enables into four interrupt lines and the
// transmit DMA request, and registers them all.
// Assumes flags and ctrl come from registers, so each output lags by one cycle.
module sc_req_gen
    import sc_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] flags,
    input  logic [NUM_CTRL-1:0]  ctrl,
    input  logic                 retx_active,
    output req_t                 req
);

    req_t nxt;
    logic rx_side_err;

    // next request levels from the current flags and enables
    always_comb begin
        rx_side_err  = flags[F_CARD_ERR] | flags[F_OVERRUN] | flags[F_PARITY];
        nxt.tx_empty = flags[F_TX_EMPTY] & ctrl[C_TXE_EN];
        nxt.tx_done  = flags[F_TX_DONE]  & ctrl[C_TXD_EN];
        nxt.rx_full  = flags[F_RX_FULL]  & ctrl[C_RX_EN] & ~ctrl[C_CPU_OFF];
        nxt.err      = (rx_side_err & ctrl[C_RX_EN])
                     | (flags[F_WAIT_TO] & ctrl[C_WAIT_EN]);
        nxt.dma      = flags[F_TX_EMPTY] & ~retx_active;
    end

    // register all request outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req <= '0;
        end else begin
            req <= nxt;
        end
    end

endmodule

// File: rtl/sc_irq_dma_unit.sv
// Module: sc_irq_dma_unit (top)
// Status flags, enable register, register port and request generation for a
// smart card serial interface. Status is write-one-to-clear at address 0,
// enables are read/write at address 1, read data is registered.
// Assumes DATA_W >= NUM_FLAGS and ADDR_W >= 1.
module sc_irq_dma_unit
    import sc_irq_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] flag_set,
    input  logic                 tdr_wr,
    input  logic                 retx_active,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 irq_tx_empty,
    output logic                 irq_rx_full,
    output logic                 irq_err,
    output logic                 irq_tx_done,
    output logic                 dma_tx_req
);

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STATUS);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);

    logic [NUM_FLAGS-1:0] flags_q;
    logic [NUM_FLAGS-1:0] flag_clr;
    logic [NUM_CTRL-1:0]  ctrl_q;
    logic                 wr_stat;
    logic                 wr_ctrl;
    logic [DATA_W-1:0]    rd_next;
    req_t                 req;

    // address decode of the write strobe
    always_comb begin
        wr_stat = wr_en && (wr_addr == A_STAT);
        wr_ctrl = wr_en && (wr_addr == A_CTRL);
    end

    // clear requests: software ones at the status address, data write on tx_empty
    always_comb begin
        flag_clr = wr_stat ? wr_data[NUM_FLAGS-1:0] : '0;
        flag_clr[F_TX_EMPTY] = flag_clr[F_TX_EMPTY] | tdr_wr;
    end

    sc_flag_bank #(
        .N   (NUM_FLAGS),
        .RST (FLAG_RST)
    ) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clr   (flag_clr),
        .q     (flags_q)
    );

    sc_ctrl_reg #(
        .W (NUM_CTRL)
    ) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_ctrl),
        .d     (wr_data[NUM_CTRL-1:0]),
        .q     (ctrl_q)
    );

    sc_req_gen u_req (
        .clk         (clk),
        .rst_n       (rst_n),
        .flags       (flags_q),
        .ctrl        (ctrl_q),
        .retx_active (retx_active),
        .req         (req)
    );

    // read multiplexer, zero-extended, unmapped addresses read zero
    always_comb begin
        rd_next = '0;
        if (rd_addr == A_STAT) begin
            rd_next[NUM_FLAGS-1:0] = flags_q;
        end else if (rd_addr == A_CTRL) begin
            rd_next[NUM_CTRL-1:0] = ctrl_q;
        end
    end

    // registered read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= rd_next;
        end
    end

    // drive the request ports from the registered request bundle
    always_comb begin
        irq_tx_empty = req.tx_empty;
        irq_rx_full  = req.rx_full;
        irq_err      = req.err;
        irq_tx_done  = req.tx_done;
        dma_tx_req   = req.dma;
    end

endmodule

// File: rtl/sc_irq_dma_chk.sv
// Module: sc_irq_dma_chk
// Assertion checker bound to sc_irq_dma_unit. Relates the ports of the block
// to its flag and enable registers across clock edges.
module sc_irq_dma_chk
    import sc_irq_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_FLAGS-1:0] flag_set,
    input logic                 tdr_wr,
    input logic                 retx_active,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    wr_addr,
    input logic [DATA_W-1:0]    wr_data,
    input logic [NUM_FLAGS-1:0] flags_q,
    input logic [NUM_CTRL-1:0]  ctrl_q,
    input logic                 irq_tx_empty,
    input logic                 irq_rx_full,
    input logic                 irq_err,
    input logic                 dma_tx_req
);

    // R2
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|flag_set) |=> ((flags_q & $past(flag_set)) == $past(flag_set)));

    // R2
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(ADDR_STATUS))
        |=> ((flags_q & $past(wr_data[NUM_FLAGS-1:0] & ~flag_set)) == '0));

    // R3
    tdr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tdr_wr && !flag_set[F_TX_EMPTY]) |=> !flags_q[F_TX_EMPTY]);

    // R9
    retx_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retx_active |=> !dma_tx_req);

    // R7
    rx_cpu_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx_full |-> $past(ctrl_q[C_RX_EN] && !ctrl_q[C_CPU_OFF] && flags_q[F_RX_FULL]));

    // R5
    txe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx_empty |-> $past(flags_q[F_TX_EMPTY] && ctrl_q[C_TXE_EN]));

    // R8
    err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> $past(flags_q[F_CARD_ERR] || flags_q[F_OVERRUN]
                          || flags_q[F_PARITY] || flags_q[F_WAIT_TO]));

endmodule

bind sc_irq_dma_unit sc_irq_dma_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flag_set     (flag_set),
    .tdr_wr       (tdr_wr),
    .retx_active  (retx_active),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .flags_q      (flags_q),
    .ctrl_q       (ctrl_q),
    .irq_tx_empty (irq_tx_empty),
    .irq_rx_full  (irq_rx_full),
    .irq_err      (irq_err),
    .dma_tx_req   (dma_tx_req)
);

// File: tb/sc_irq_dma_unit_test.sv
// Bench for sc_irq_dma_unit: behavioural reference model updated on each
// rising edge, every output compared on each falling edge.
module sc_irq_dma_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 2;
    localparam int DATA_W = 8;
    localparam int WATCHDOG = 100000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [6:0]        flag_set = '0;
    logic              tdr_wr = 1'b0;
    logic              retx_active = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] rd_data;
    logic irq_tx_empty, irq_rx_full, irq_err, irq_tx_done, dma_tx_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sc_irq_dma_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n), .flag_set(flag_set), .tdr_wr(tdr_wr),
        .retx_active(retx_active), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_tx_empty(irq_tx_empty), .irq_rx_full(irq_rx_full),
        .irq_err(irq_err), .irq_tx_done(irq_tx_done), .dma_tx_req(dma_tx_req)
    );

    // ---------------- reference model ----------------
    bit [6:0] m_flags;
    bit [4:0] m_ctrl;
    bit [6:0] nf;
    bit e_txe, e_rxf, e_err, e_txd, e_dma;
    bit [7:0] e_rd;

    always @(posedge clk) begin
        cycles = cycles + 1;
        if (!rst_n) begin
            m_flags = 7'h03; m_ctrl = '0;
            e_txe = 0; e_rxf = 0; e_err = 0; e_txd = 0; e_dma = 0; e_rd = 0;
        end else begin
            // outputs use the state held before this edge
            e_txe = m_flags[0] && m_ctrl[0];
            e_txd = m_flags[1] && m_ctrl[2];
            e_rxf = m_flags[2] && m_ctrl[1] && !m_ctrl[4];
            e_err = ((m_flags[3] || m_flags[4] || m_flags[5]) && m_ctrl[1])
                    || (m_flags[6] && m_ctrl[3]);
            e_dma = m_flags[0] && !retx_active;
            if (rd_addr == 0)      e_rd = {1'b0, m_flags};
            else if (rd_addr == 1) e_rd = {3'b000, m_ctrl};
            else                   e_rd = 8'h00;
            nf = m_flags;
            if (wr_en && wr_addr == 0) nf = nf & ~wr_data[6:0];
            if (tdr_wr) nf[0] = 1'b0;
            nf = nf | flag_set;
            m_flags = nf;
            if (wr_en && wr_addr == 1) m_ctrl = wr_data[4:0];
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    task automatic compare_all();
        chk("R5", "irq_tx_empty", int'(irq_tx_empty), int'(e_txe));
        chk("R6", "irq_tx_done",  int'(irq_tx_done),  int'(e_txd));
        chk("R7", "irq_rx_full",  int'(irq_rx_full),  int'(e_rxf));
        chk("R8", "irq_err",      int'(irq_err),      int'(e_err));
        chk("R9", "dma_tx_req",   int'(dma_tx_req),   int'(e_dma));
        // R2 R3 R4 R10: flag and enable state seen through the read port
        chk("R10", "rd_data",     int'(rd_data),      int'(e_rd));
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
        flag_set = '0; tdr_wr = 0; wr_en = 0;
    endtask

    task automatic idle_reads(input int n);
        for (int i = 0; i < n; i++) begin
            rd_addr = ADDR_W'(i % 2);
            step();
        end
    endtask

    bit [31:0] lfsr = 32'h1d2c_3b4a;
    function automatic bit [31:0] rnd(input bit [31:0] s);
        bit [31:0] x = s;
        x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
        return x;
    endfunction

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "irq_tx_empty in reset", int'(irq_tx_empty), 0);
        chk("R1", "irq_err in reset", int'(irq_err), 0);
        chk("R1", "dma_tx_req in reset", int'(dma_tx_req), 0);
        chk("R1", "rd_data in reset", int'(rd_data), 0);
        rst_n = 1'b1;
        rd_addr = 0;
        step();
        step();
        chk("R1", "status after reset", int'(rd_data), 8'h03);

        // R4: enable everything except the CPU-off bit
        wr_en = 1; wr_addr = 1; wr_data = 8'hEF;
        @(negedge clk); compare_all(); wr_en = 0;
        rd_addr = 1; step(); step();
        chk("R4", "ctrl readback", int'(rd_data), 8'h0F);

        // R2 R5..R8: set each flag alone, observe, clear by W1C
        for (int b = 0; b < 7; b++) begin
            flag_set = 7'(1 << b);
            step();
            idle_reads(3);
            wr_en = 1; wr_addr = 0; wr_data = 8'(1 << b);
            @(negedge clk); compare_all(); wr_en = 0;
            idle_reads(3);
        end

        // R2 R3: set, W1C and data write in the same cycle on every flag
        for (int b = 0; b < 7; b++) begin
            flag_set = 7'(1 << b); tdr_wr = 1;
            wr_en = 1; wr_addr = 0; wr_data = 8'h7F;
            rd_addr = 0;
            @(negedge clk); compare_all(); flag_set = 0; tdr_wr = 0; wr_en = 0;
            idle_reads(2);
        end

        // R7: CPU-off hides rx_full
        wr_en = 1; wr_addr = 1; wr_data = 8'h12;
        @(negedge clk); compare_all(); wr_en = 0;
        flag_set = 7'b000_0100; step(); idle_reads(3);

        // R9: retransmission masks DMA, tdr_wr drops the level
        flag_set = 7'b000_0001; step();
        retx_active = 1; idle_reads(4);
        retx_active = 0; idle_reads(3);
        tdr_wr = 1; @(negedge clk); compare_all(); tdr_wr = 0;
        idle_reads(3);

        // R10: unmapped addresses
        wr_en = 1; wr_addr = 3; wr_data = 8'hFF;
        @(negedge clk); compare_all(); wr_en = 0;
        rd_addr = 2; step(); step();
        chk("R10", "unmapped read", int'(rd_data), 0);

        // random phase: all functions overlapping
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            compare_all();
            lfsr = rnd(lfsr);
            for (int b = 0; b < 7; b++) flag_set[b] = (lfsr[b*4 +: 4] == 4'h0);
            lfsr = rnd(lfsr);
            tdr_wr = (lfsr[3:0] == 4'h1);
            wr_en = (lfsr[7:4] < 4'h3);
            wr_addr = lfsr[9:8];
            wr_data = lfsr[17:10];
            rd_addr = lfsr[19:18];
            if (lfsr[27:24] == 4'h2) retx_active = ~retx_active;
            if (lfsr[31:28] == 4'h0 && i > 10000) rst_n = (lfsr[23:20] != 0);
            else rst_n = 1'b1;
        end
        step();
        done = 1'b1;
    end

    initial begin
        wait (done || cycles >= WATCHDOG);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired at cycle %0d", cycles);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule